// File: doc/BRIEF.md
# Pulsed Amplifier Gate Watchdog

This block protects a pulsed RF power stage from thermal overload. It watches the gate control signal that turns the amplifier bias on. It sends that signal on through a single combinational AND, so the protected path gains no register delay. On every sample tick (nominally one per millisecond) it records the gate level. It keeps two measures of recent activity: the number of on-samples among the last 5000 ticks (about five seconds), and the length of the current unbroken run of on-samples.

Two 3-bit fields of an 8-bit configuration switch input select a duty limit and a continuous on-time limit from fixed non-linear tables. If either limit is exceeded, a sticky fault forces the gate output low and records which limit tripped. Only the reset input clears the fault. A 0 to 100 percent duty reading derived from the window count is provided for an external display.

Top module: `gate_watchdog`

## Requirements
- R1: Samples are taken only in cycles where `tick` is 1. The level of `gate_in` in cycles with `tick` at 0 affects neither the window count nor the on-run length.
- R2: The duty count is the number of on-samples among the most recent 5000 ticks. On each tick the new sample enters and the sample taken 5000 ticks earlier leaves. After reset the history is all zeros.
- R3: `sw[2:0]` (sw[0] is the least significant bit) selects the duty limit. Codes 0..7 give 1, 2, 5, 10, 15, 20, 25 and 30 percent. A duty fault occurs on the tick at which the count becomes greater than the percentage times 50.
- R4: `sw[5:3]` (sw[3] is the least significant bit) selects the on-time limit. Codes 0..7 give 10, 25, 50, 100, 250, 500, 1000 and 2000 ticks. An on-time fault occurs on the tick at which the count of consecutive on-samples becomes greater than the limit. Any off-sample clears the run.
- R5: `sw[7:6]` are reserved and have no effect on any output.
- R6: `gate_out` equals `gate_in` AND NOT `fault`, combinationally, with no clocked stage.
- R7: A fault takes effect at the clock edge of the tick that crosses a limit. It stays set, holding `gate_out` at 0, until `rst_n` is asserted.
- R8: `fault_cause` is 0 with no fault, 1 for a duty fault and 2 for an on-time fault. If both limits are crossed on the same tick, the code is 1. The code stays frozen while the fault is held.
- R9: `duty_pct` equals the window count divided by 50, rounded down, and is always in 0..100.
- R10: After reset, `fault` is 0, `fault_cause` is 0 and `duty_pct` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle sample strobe, nominally 1 ms apart |
| gate_in | input | 1 | Amplifier gate request |
| sw | input | 8 | Limit switches: [2:0] duty code, [5:3] on-time code, [7:6] reserved |
| gate_out | output | 1 | Protected gate, gate_in AND NOT fault |
| fault | output | 1 | Sticky fault flag |
| fault_cause | output | 2 | 0 none, 1 duty limit, 2 on-time limit |
| duty_pct | output | 7 | Window duty in percent, count divided by 50 |

## Verification
On every cycle the assertions check the following. The fault never drops outside reset, and the cause code is valid and frozen while the fault is held. A fault only rises after a tick, a low gate request never yields a high output, a faulted block never passes the gate, and the duty reading stays within 0..100. Only the bench scenarios can show the rest, checked against an independent window model on every tick. These are the exact tick on which each table entry trips, the tie between the two limits, the way old samples age out of the sliding history, that samples between ticks are ignored, and that the reserved switch bits change nothing.

// File: rtl/gw_pkg.sv
package gw_pkg;

  localparam int DUTY_CODES   = 8;
  localparam int ONTIME_MAX   = 2000;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_DUTY = 2'd1,
    CAUSE_RUN  = 2'd2
  } cause_e;

  // Duty percentage selected by a 3-bit switch code.
  function automatic int unsigned duty_pct_of(input logic [2:0] code);
    int unsigned v;
    case (code)
      3'd0:    v = 1;
      3'd1:    v = 2;
      3'd2:    v = 5;
      3'd3:    v = 10;
      3'd4:    v = 15;
      3'd5:    v = 20;
      3'd6:    v = 25;
      default: v = 30;
    endcase
    return v;
  endfunction

  // Continuous on-time limit in ticks selected by a 3-bit switch code.
  function automatic int unsigned ontime_of(input logic [2:0] code);
    int unsigned v;
    case (code)
      3'd0:    v = 10;
      3'd1:    v = 25;
      3'd2:    v = 50;
      3'd3:    v = 100;
      3'd4:    v = 250;
      3'd5:    v = 500;
      3'd6:    v = 1000;
      default: v = ONTIME_MAX;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/gw_limits.sv
module gw_limits #(
  parameter int WIN   = 5000,
  parameter int CNT_W = $clog2(WIN + 1),
  parameter int RUN_W = 11
) (
  input  logic [2:0]       duty_code,
  input  logic [2:0]       run_code,
  output logic [CNT_W-1:0] duty_max,
  output logic [RUN_W-1:0] run_max
);

  localparam int NCODES = gw_pkg::DUTY_CODES;

  logic [CNT_W-1:0] duty_tab [NCODES];
  logic [RUN_W-1:0] run_tab  [NCODES];

  for (genvar i = 0; i < NCODES; i++) begin : g_tab
    assign duty_tab[i] = CNT_W'((gw_pkg::duty_pct_of(3'(i)) * WIN) / 100);
    assign run_tab[i]  = RUN_W'(gw_pkg::ontime_of(3'(i)));
  end

  assign duty_max = duty_tab[duty_code];
  assign run_max  = run_tab[run_code];

endmodule

// File: rtl/gw_window.sv
module gw_window #(
  parameter int WIN   = 5000,
  parameter int WORD  = 32,
  parameter int CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sample,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt
);

  localparam int IDX_W  = $clog2(WIN);
  localparam int BIT_W  = $clog2(WORD);
  localparam int NWORDS = (WIN + WORD - 1) / WORD;
  localparam int WSEL_W = IDX_W - BIT_W;

  logic [WORD-1:0]  mem_q [NWORDS];
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [WSEL_W-1:0] wsel;
  logic [BIT_W-1:0]  bsel;
  logic [WORD-1:0]   word_rd, word_d;
  logic              old_bit;

  assign wsel    = ptr_q[IDX_W-1:BIT_W];
  assign bsel    = ptr_q[BIT_W-1:0];
  assign word_rd = mem_q[wsel];
  assign old_bit = word_rd[bsel];

  always_comb begin
    ptr_d   = ptr_q;
    count_d = count_q;
    word_d  = word_rd;
    if (tick) begin
      word_d[bsel] = sample;
      count_d      = count_q + CNT_W'(sample) - CNT_W'(old_bit);
      ptr_d        = (ptr_q == IDX_W'(WIN - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      count_q <= '0;
    end else if (tick) begin
      ptr_q   <= ptr_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem_q[i] <= '0;
    end else if (tick) begin
      mem_q[wsel] <= word_d;
    end
  end

  assign count     = count_q;
  assign count_nxt = count_d;

endmodule

// File: rtl/gw_run.sv
module gw_run #(
  parameter int RUN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sample,
  output logic [RUN_W-1:0] run_nxt
);

  localparam logic [RUN_W-1:0] RUN_TOP = '1;

  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (tick) begin
      if (!sample)              run_d = '0;
      else if (run_q != RUN_TOP) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (tick) run_q <= run_d;
  end

  assign run_nxt = run_d;

endmodule

// File: rtl/gw_fault.sv
module gw_fault #(
  parameter int CNT_W = 13,
  parameter int RUN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [CNT_W-1:0] duty_max,
  input  logic [RUN_W-1:0] run_nxt,
  input  logic [RUN_W-1:0] run_max,
  output logic             fault,
  output gw_pkg::cause_e   cause
);

  logic           fault_q, fault_d;
  gw_pkg::cause_e cause_q, cause_d;
  logic           duty_over, run_over;

  assign duty_over = count_nxt > duty_max;
  assign run_over  = run_nxt > run_max;

  always_comb begin
    fault_d = fault_q;
    cause_d = cause_q;
    if (tick && !fault_q) begin
      if (duty_over) begin
        fault_d = 1'b1;
        cause_d = gw_pkg::CAUSE_DUTY;
      end else if (run_over) begin
        fault_d = 1'b1;
        cause_d = gw_pkg::CAUSE_RUN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= gw_pkg::CAUSE_NONE;
    end else if (tick && !fault_q) begin
      fault_q <= fault_d;
      cause_q <= cause_d;
    end
  end

  assign fault = fault_q;
  assign cause = cause_q;

endmodule

// File: rtl/gate_watchdog.sv
module gate_watchdog #(
  parameter int WIN  = 5000,
  parameter int WORD = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       gate_in,
  input  logic [7:0] sw,
  output logic       gate_out,
  output logic       fault,
  output logic [1:0] fault_cause,
  output logic [6:0] duty_pct
);

  localparam int CNT_W = $clog2(WIN + 1);
  localparam int RUN_W = $clog2(gw_pkg::ONTIME_MAX + 2);
  localparam int SCL_W = CNT_W + 7;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [CNT_W-1:0] count, count_nxt, duty_max;
  logic [RUN_W-1:0] run_nxt, run_max;
  logic             fault_q;
  gw_pkg::cause_e   cause;
  logic [SCL_W-1:0] scaled, pct_full;
  logic             unused_sw;

  // Assert asynchronously, release on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign unused_sw = ^sw[7:6];

  gw_limits #(.WIN(WIN), .CNT_W(CNT_W), .RUN_W(RUN_W)) u_limits (
    .duty_code (sw[2:0]),
    .run_code  (sw[5:3]),
    .duty_max  (duty_max),
    .run_max   (run_max)
  );

  gw_window #(.WIN(WIN), .WORD(WORD), .CNT_W(CNT_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (tick),
    .sample    (gate_in),
    .count     (count),
    .count_nxt (count_nxt)
  );

  gw_run #(.RUN_W(RUN_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (tick),
    .sample  (gate_in),
    .run_nxt (run_nxt)
  );

  gw_fault #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_fault (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (tick),
    .count_nxt (count_nxt),
    .duty_max  (duty_max),
    .run_nxt   (run_nxt),
    .run_max   (run_max),
    .fault     (fault_q),
    .cause     (cause)
  );

  assign gate_out    = gate_in & ~fault_q;
  assign fault       = fault_q;
  assign fault_cause = cause;

  assign scaled   = {7'd0, count} * SCL_W'(100);
  assign pct_full = scaled / SCL_W'(WIN);
  assign duty_pct = pct_full[6:0];

endmodule

// File: rtl/gw_checker.sv
module gw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       gate_in,
  input logic       gate_out,
  input logic       fault,
  input logic [1:0] fault_cause,
  input logic [6:0] duty_pct
);

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !gate_out);

  p_rise_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(tick));

  p_cause_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> $stable(fault_cause));

  p_cause_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_cause == 2'd1 || fault_cause == 2'd2));

  p_cause_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (fault_cause == 2'd0));

  p_duty_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    duty_pct <= 7'd100);

  always_comb begin
    if (rst_n && !gate_in) p_no_false_on_r6: assert (!gate_out);
  end

endmodule

bind gate_watchdog gw_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .gate_in     (gate_in),
  .gate_out    (gate_out),
  .fault       (fault),
  .fault_cause (fault_cause),
  .duty_pct    (duty_pct)
);

// File: tb/sim_gate_watchdog.sv
`timescale 1ns/1ps
module sim_gate_watchdog;

  localparam int W = 5000;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       gate_in;
  logic [7:0] sw;
  logic       gate_out;
  logic       fault;
  logic [1:0] fault_cause;
  logic [6:0] duty_pct;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  bit q[$];
  int m_cnt, m_run, m_dmax, m_rmax;
  bit m_fault;
  int m_cause;

  gate_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate_in(gate_in), .sw(sw),
    .gate_out(gate_out), .fault(fault), .fault_cause(fault_cause),
    .duty_pct(duty_pct)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int pct_tab(input int c);
    int t [8] = '{1, 2, 5, 10, 15, 20, 25, 30};
    return t[c];
  endfunction

  function automatic int ms_tab(input int c);
    int t [8] = '{10, 25, 50, 100, 250, 500, 1000, 2000};
    return t[c];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    check(fault == m_fault, req, fault, m_fault);
    check(fault_cause == 2'(m_cause), "R8", fault_cause, m_cause);
    check(duty_pct == 7'(m_cnt / 50), "R9", duty_pct, m_cnt / 50);
    check(gate_out == (gate_in & ~m_fault), "R6", gate_out, gate_in & ~m_fault);
  endtask

  task automatic do_reset(input logic [7:0] s);
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; gate_in = 1'b0; sw = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    q.delete();
    for (int i = 0; i < W; i++) q.push_back(1'b0);
    m_cnt = 0; m_run = 0; m_fault = 1'b0; m_cause = 0;
    m_dmax = pct_tab(int'(s[2:0])) * 50;
    m_rmax = ms_tab(int'(s[5:3]));
  endtask

  // one tick with sample g, then gap idle cycles with gate_in at idle
  task automatic step(input bit g, input int gap, input bit idle, input string req);
    gate_in = g; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    q.push_back(g);
    m_cnt += int'(g);
    m_cnt -= int'(q.pop_front());
    m_run = g ? m_run + 1 : 0;
    if (!m_fault) begin
      if (m_cnt > m_dmax)      begin m_fault = 1'b1; m_cause = 1; end
      else if (m_run > m_rmax) begin m_fault = 1'b1; m_cause = 2; end
    end
    compare(req);
    for (int k = 0; k < gap; k++) begin
      gate_in = idle;
      @(negedge clk);
      check(gate_out == (idle & ~m_fault), "R6", gate_out, idle & ~m_fault);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; gate_in = 1'b0; sw = 8'h00;

    // R10 reset state
    do_reset(8'b00_111_111);
    check(fault == 1'b0, "R10", fault, 0);
    check(fault_cause == 2'd0, "R10", fault_cause, 0);
    check(duty_pct == 7'd0, "R10", duty_pct, 0);
    gate_in = 1'b1; #1;
    check(gate_out == 1'b1, "R6", gate_out, 1);
    gate_in = 1'b0; #1;
    check(gate_out == 1'b0, "R6", gate_out, 0);

    // R4 on-time sweep, reserved bits R5 varied
    for (int c = 0; c < 8; c++) begin
      int n;
      do_reset({2'(c), 3'(c), 3'd7});
      n = (ms_tab(c) + 1 > 1501) ? 1501 : ms_tab(c) + 1;
      for (int t = 0; t < n; t++) step(1'b1, 0, 1'b0, "R4");
      check(fault == 1'b1, "R4", fault, 1);
      check(fault_cause == ((c == 7) ? 2'd1 : 2'd2), "R5", fault_cause, (c == 7) ? 1 : 2);
    end

    // R3 duty sweep with alternating samples
    for (int c = 0; c < 8; c++) begin
      int d;
      do_reset({2'b11 ^ 2'(c), 3'd7, 3'(c)});
      d = pct_tab(c) * 50;
      for (int t = 0; t < 2 * d + 4; t++) step(1'(t % 2 == 0), 0, 1'b0, "R3");
      check(fault == 1'b1, "R3", fault, 1);
      check(fault_cause == 2'd1, "R3", fault_cause, 1);
    end

    // R8 both limits crossed on the same tick (50 and 50)
    do_reset(8'b00_010_000);
    for (int t = 0; t < 51; t++) step(1'b1, 0, 1'b0, "R8");
    check(fault_cause == 2'd1, "R8", fault_cause, 1);
    // R7 fault held with further samples; then cleared by reset
    for (int t = 0; t < 200; t++) step(1'(t % 3 == 0), 0, 1'b1, "R7");
    check(fault == 1'b1, "R7", fault, 1);
    gate_in = 1'b1; #1;
    check(gate_out == 1'b0, "R7", gate_out, 0);
    do_reset(8'b00_111_111);
    check(fault == 1'b0, "R7", fault, 0);

    // R1 idle cycles with gate high must not be sampled (10-tick run limit)
    do_reset(8'b00_000_111);
    for (int t = 0; t < 200; t++) step(1'(t % 2 == 0), 2, 1'b1, "R1");
    check(fault == 1'b0, "R1", fault, 0);
    check(duty_pct == 7'd2, "R1", duty_pct, 2);

    // R2 sliding window: 50 spaced ons age out, then 50 more do not trip
    do_reset(8'b00_111_000);
    for (int t = 0; t < 500; t++) step(1'(t % 10 == 0), 0, 1'b0, "R2");
    for (int t = 0; t < W; t++) step(1'b0, 0, 1'b0, "R2");
    check(duty_pct == 7'd0, "R2", duty_pct, 0);
    for (int t = 0; t < 500; t++) step(1'(t % 10 == 0), 0, 1'b0, "R2");
    check(fault == 1'b0, "R2", fault, 0);
    step(1'b1, 0, 1'b0, "R3");
    check(fault == 1'b1, "R3", fault, 1);
    check(fault_cause == 2'd1, "R3", fault_cause, 1);

    // R9 steady 25 percent pattern over a full window
    do_reset(8'b00_111_111);
    for (int t = 0; t < W + 8; t++) step(1'(t % 4 == 0), 0, 1'b0, "R9");
    check(duty_pct == 7'd25, "R9", duty_pct, 25);
    check(fault == 1'b0, "R9", fault, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule